// File: doc/BRIEF.md
# LIN Error Status Flag Register

This block holds the error flags of a LIN serial controller as one 32-bit register that software can read. The protocol engine reports each error as a one-cycle set pulse. The block turns each pulse into a sticky flag, and the flag stays set until software writes a one to its bit. The register answers at offset 0x0C of the controller's register window. Reads complete in zero wait states and have no side effects.

Two configuration inputs disable checksum handling. While either one is high, checksum error pulses are ignored. A timeout-mode control bit decides what happens to the output-compare flag in initialization mode: it is either held clear there or keeps its value. When the output-compare flag is set and idle-on-timeout is enabled, the block asks the controller to return to idle. A registered interrupt output combines every flag with its own enable input.

Top module: `lin_err_status`

## Requirements
- R1: The register decodes only at offset 0x0C. A read at any other address returns zero. A write at any other address changes no flag.
- R2: Flag bit positions are: noise 0, buffer overrun 7, framing 8, identifier parity 9, break delimiter 10, synch field 11, checksum 12, bit error 13, output compare 14, stuck-at-zero 15. Bits 31:16 and 6:1 always read zero, and writing ones to them has no effect.
- R3: A set pulse on a flag's input makes that flag read 1 after the next clock edge. The flag stays 1 until a write to 0x0C has a 1 in its bit. Writing 0 to a bit leaves that bit unchanged.
- R4: If a set pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R5: While either checksum disable input is high, a checksum set pulse does not set the checksum flag.
- R6: While the timeout-mode input and the initialization-mode input are both 1, the output-compare flag is cleared at every clock edge, even if its set pulse is high. When the timeout-mode input is 0, the flag keeps its value in either mode.
- R7: idle_req_o is high in exactly those cycles in which the output-compare flag reads 1 and idle_on_to_i is 1.
- R8: irq_o is registered. One cycle after any flag is set together with its enable bit (enable index k: 0 noise, 1 overrun, 2 framing, 3 id parity, 4 break delimiter, 5 synch, 6 checksum, 7 bit error, 8 output compare, 9 stuck-at-zero), irq_o is 1. Otherwise it is 0.
- R9: After reset every flag reads 0, and irq_o and idle_req_o are 0.
- R10: Repeated reads with no set pulse and no write return the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W (8) | Register byte offset |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data; a 1 clears the flag in that bit |
| rdata_o | output | 32 | Read data, combinational |
| set_i | input | 10 | Hardware set pulses, index order as in R8 |
| irq_en_i | input | 10 | Per-flag interrupt enables, index order as in R8 |
| init_mode_i | input | 1 | Controller is in initialization mode |
| cks_calc_dis_i | input | 1 | Checksum calculation disabled |
| cks_field_dis_i | input | 1 | Checksum field disabled |
| to_mode_i | input | 1 | Timeout mode: output-compare flag cleared in init mode |
| idle_on_to_i | input | 1 | Idle-on-timeout enable |
| irq_o | output | 1 | Combined error interrupt, registered |
| idle_req_o | output | 1 | Request to return to idle |

## Verification
Every flag is visible at offset 0x0C in the same cycle that it changes. A flag that sets wrongly, clears wrongly or is lost therefore shows up as a readback mismatch at the first sample after the faulty clock edge. A fault in the interrupt or idle path shows up on irq_o one cycle later and on idle_req_o at once. Because of this, the reference model is compared against all outputs on every cycle, across directed corner cases and a long stretch of random set pulses and writes.

// File: rtl/lin_err_pkg.sv
package lin_err_pkg;
  localparam int N_FLAGS = 10;
  localparam int REG_W   = 32;

  localparam int F_NOISE = 0;
  localparam int F_BOV   = 1;
  localparam int F_FRM   = 2;
  localparam int F_IDP   = 3;
  localparam int F_BDL   = 4;
  localparam int F_SYN   = 5;
  localparam int F_CKS   = 6;
  localparam int F_BIT   = 7;
  localparam int F_OC    = 8;
  localparam int F_SZ    = 9;

  // index 0 sits at bit 0; the rest are packed from bit 7 upward
  function automatic int flag_pos(int k);
    return (k == 0) ? 0 : k + 6;
  endfunction
endpackage

// File: rtl/lin_err_flag.sv
module lin_err_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hw_clr_i,
  input  logic set_i,
  input  logic sw_clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q_o <= 1'b0;
    else if (hw_clr_i) q_o <= 1'b0;
    else if (set_i)    q_o <= 1'b1;  // set beats software clear
    else if (sw_clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/lin_err_irq.sv
module lin_err_irq #(
  parameter int N = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] flags_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |(flags_i & en_i);
  end
endmodule

// File: rtl/lin_err_status.sv
module lin_err_status
  import lin_err_pkg::*;
#(
  parameter int               ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] REG_OFS = 8'h0C
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [REG_W-1:0]   rdata_o,
  input  logic [N_FLAGS-1:0] set_i,
  input  logic [N_FLAGS-1:0] irq_en_i,
  input  logic               init_mode_i,
  input  logic               cks_calc_dis_i,
  input  logic               cks_field_dis_i,
  input  logic               to_mode_i,
  input  logic               idle_on_to_i,
  output logic               irq_o,
  output logic               idle_req_o
);
  logic               hit;
  logic               wr_hit;
  logic [N_FLAGS-1:0] flags_q;
  logic [REG_W-1:0]   reg_img;
  logic               cks_block;
  logic               oc_hold_clr;

  assign hit         = (addr_i == REG_OFS);
  assign wr_hit      = we_i & hit;
  assign cks_block   = cks_calc_dis_i | cks_field_dis_i;
  assign oc_hold_clr = to_mode_i & init_mode_i;

  for (genvar k = 0; k < N_FLAGS; k++) begin : g_flag
    localparam int P = flag_pos(k);
    logic set_eff;
    logic hw_clr;
    if (k == F_CKS) begin : g_cks
      assign set_eff = set_i[k] & ~cks_block;
    end else begin : g_plain
      assign set_eff = set_i[k];
    end
    if (k == F_OC) begin : g_oc
      assign hw_clr = oc_hold_clr;
    end else begin : g_nohc
      assign hw_clr = 1'b0;
    end
    lin_err_flag u_flag (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .hw_clr_i (hw_clr),
      .set_i    (set_eff),
      .sw_clr_i (wr_hit & wdata_i[P]),
      .q_o      (flags_q[k])
    );
  end

  always_comb begin
    reg_img = '0;
    for (int k = 0; k < N_FLAGS; k++) reg_img[flag_pos(k)] = flags_q[k];
  end

  assign rdata_o    = hit ? reg_img : '0;
  assign idle_req_o = flags_q[F_OC] & idle_on_to_i;

  lin_err_irq #(.N(N_FLAGS)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flags_i (flags_q),
    .en_i    (irq_en_i),
    .irq_o   (irq_o)
  );

  // reserved write bits carry no state
  logic unused_wbits;
  assign unused_wbits = ^{wdata_i[31:16], wdata_i[6:1]};
endmodule

// File: rtl/lin_err_status_chk.sv
module lin_err_status_chk
  import lin_err_pkg::*;
#(
  parameter int               ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] REG_OFS = 8'h0C
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [ADDR_W-1:0]  addr_i,
  input logic               we_i,
  input logic [REG_W-1:0]   wdata_i,
  input logic [REG_W-1:0]   rdata_o,
  input logic [N_FLAGS-1:0] set_i,
  input logic [N_FLAGS-1:0] irq_en_i,
  input logic [N_FLAGS-1:0] flags_q,
  input logic               init_mode_i,
  input logic               cks_calc_dis_i,
  input logic               cks_field_dis_i,
  input logic               to_mode_i,
  input logic               idle_on_to_i,
  input logic               irq_o,
  input logic               idle_req_o
);
  // R2
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[31:16] == 16'h0) && (rdata_o[6:1] == 6'h0));

  // R4
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i[F_NOISE] |=> flags_q[F_NOISE]);

  // R3
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_q[F_NOISE] && !(we_i && addr_i == REG_OFS && wdata_i[0]) |=> flags_q[F_NOISE]);

  // R5
  cks_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cks_calc_dis_i || cks_field_dis_i) && !flags_q[F_CKS] |=> !flags_q[F_CKS]);

  // R6
  oc_init_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_mode_i && init_mode_i |=> !flags_q[F_OC]);

  // R7
  idle_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flags_q[F_OC] |-> !idle_req_o);

  // R8
  irq_lag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(flags_q & irq_en_i) |=> irq_o);
endmodule

bind lin_err_status lin_err_status_chk #(.ADDR_W(ADDR_W), .REG_OFS(REG_OFS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i), .wdata_i(wdata_i),
  .rdata_o(rdata_o), .set_i(set_i), .irq_en_i(irq_en_i), .flags_q(flags_q),
  .init_mode_i(init_mode_i), .cks_calc_dis_i(cks_calc_dis_i),
  .cks_field_dis_i(cks_field_dis_i), .to_mode_i(to_mode_i),
  .idle_on_to_i(idle_on_to_i), .irq_o(irq_o), .idle_req_o(idle_req_o)
);

// File: tb/lin_err_status_test.sv
module lin_err_status_test;
  localparam int NF = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = 8'h0C;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NF-1:0] set = '0;
  logic [NF-1:0] en = '0;
  logic init_m = 1'b0, ccd = 1'b0, cfd = 1'b0, tom = 1'b0, iot = 1'b0;
  logic irq, idle;

  int vectors = 0;
  int fails = 0;
  int pos [NF] = '{0, 7, 8, 9, 10, 11, 12, 13, 14, 15};

  logic [31:0] m_reg = '0;
  logic        m_irq = 1'b0;

  always #2.5 clk = ~clk;

  lin_err_status uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .set_i(set), .irq_en_i(en), .init_mode_i(init_m),
    .cks_calc_dis_i(ccd), .cks_field_dis_i(cfd), .to_mode_i(tom),
    .idle_on_to_i(iot), .irq_o(irq), .idle_req_o(idle)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg = '0;
      m_irq = 1'b0;
    end else begin
      logic any;
      logic [31:0] nx;
      any = 1'b0;
      for (int k = 0; k < NF; k++) if (en[k] && m_reg[pos[k]]) any = 1'b1;
      nx = m_reg;
      if (we && addr == 8'h0C) nx = nx & ~wdata;
      for (int k = 0; k < NF; k++)
        if (set[k] && !(k == 6 && (ccd || cfd))) nx[pos[k]] = 1'b1;
      if (tom && init_m) nx[14] = 1'b0;
      m_reg = nx & 32'h0000_FF81;
      m_irq = any;
    end
  end

  always @(negedge clk) begin
    check("R3 readback", rdata, (addr == 8'h0C) ? m_reg : 32'h0);
    check("R7 idle", {31'h0, idle}, {31'h0, m_reg[14] & iot});
    check("R8 irq", {31'h0, irq}, {31'h0, m_irq});
  end

  task automatic cyc();
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    cyc(); cyc();
    check("R9 reset rdata", rdata, 32'h0);
    check("R9 reset outs", {30'h0, irq, idle}, 32'h0);
    #1 rst_n = 1'b1;
    cyc();
    #1 set = '1;
    cyc();
    #1 set = '0;
    cyc();
    check("R2 R3 all flags", rdata, 32'h0000_FF81);
    check("R7 idle off", {31'h0, idle}, 32'h0);
    #1 iot = 1'b1;
    cyc();
    check("R7 idle on", {31'h0, idle}, 32'h1);
    #1 en = 10'b1;
    cyc(); cyc();
    check("R8 irq set", {31'h0, irq}, 32'h1);
    check("R10 reread", rdata, 32'h0000_FF81);
    cyc();
    check("R10 reread2", rdata, 32'h0000_FF81);
    #1 begin we = 1'b1; wdata = 32'h0; end
    cyc();
    check("R3 write zero", rdata, 32'h0000_FF81);
    #1 wdata = 32'hFFFF_007E;
    cyc();
    check("R2 reserved write", rdata, 32'h0000_FF81);
    #1 begin addr = 8'h08; wdata = '1; end
    cyc();
    check("R1 other addr read", rdata, 32'h0);
    #1 begin we = 1'b0; addr = 8'h0C; end
    cyc();
    check("R1 other addr write", rdata, 32'h0000_FF81);
    #1 begin we = 1'b1; wdata = 32'h80; end
    cyc();
    check("R3 w1c overrun", rdata, 32'h0000_FF01);
    #1 begin wdata = 32'h1; set = 10'b1; end
    cyc();
    check("R4 set wins", rdata, 32'h0000_FF01);
    #1 begin set = '0; wdata = '1; end
    cyc();
    check("R3 clear all", rdata, 32'h0);
    #1 begin we = 1'b0; ccd = 1'b1; set = 10'b00_0100_0000; end
    cyc();
    check("R5 calc disable", rdata, 32'h0);
    #1 begin ccd = 1'b0; cfd = 1'b1; end
    cyc();
    check("R5 field disable", rdata, 32'h0);
    #1 begin cfd = 1'b0; tom = 1'b1; init_m = 1'b1; set = 10'b01_0000_0000; end
    cyc();
    check("R6 oc held clear", rdata, 32'h0);
    #1 tom = 1'b0;
    cyc();
    #1 set = '0;
    cyc();
    check("R6 oc kept", rdata, 32'h0000_4000);
    #1 tom = 1'b1;
    cyc();
    check("R6 oc cleared", rdata, 32'h0);
    #1 begin tom = 1'b0; init_m = 1'b0; end
    for (int i = 0; i < 6000; i++) begin
      cyc();
      #1 begin
        set    = ($urandom % 4 == 0) ? NF'($urandom) & NF'($urandom) : '0;
        we     = ($urandom % 3 == 0);
        wdata  = $urandom;
        addr   = ($urandom % 5 == 0) ? 8'($urandom) : 8'h0C;
        en     = NF'($urandom);
        init_m = $urandom;
        ccd    = ($urandom % 4 == 0);
        cfd    = ($urandom % 4 == 0);
        tom    = $urandom;
        iot    = $urandom;
        if (i == 3000) rst_n = 1'b0;
        if (i == 3003) rst_n = 1'b1;
      end
    end
    cyc();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule